// File: doc/BRIEF.md
# Clock lock-wait supervisor

This block sits beside a PLL-based spread-spectrum clock generator and decides when the generated clock may leave the block. It watches an active-low power-down input and the configuration pins: the frequency-range select, the modulation enable and a band select. While power-down is active, the clock output is held low. Leaving power-down starts a lock wait, and so does any change on a configuration pin. Only when that wait has fully elapsed does the block open its output gate and raise a ready signal. Downstream logic uses the ready signal as its reset release.

All timing is counted in cycles of a free-running timebase clock. The wait length is a parameter given in timebase cycles. The band select picks one of two lengths: the short one covers inputs up to 80 MHz (5 ms worst case) and the long one covers the upper band (8 ms worst case). The PLL itself lies outside the block. Its clock arrives on a separate input and is gated onto the output.

Top module: `clk_lock_supervisor`

## Requirements
- R1: While reset is asserted, `ready_o` is 0 and `clk_o` is 0.
- R2: After a change on any configuration pin (`freq_sel_i`, `mod_en_i`, `band_hi_i`), `ready_o` is still 1 at the first falling timebase edge and is 0 from the second falling timebase edge onward. This is the two-flop synchronizer latency, with the drop in the same cycle the change is detected.
- R3: With `band_hi_i` = 0, `ready_o` rises exactly LOCK_LO_CYC + 3 timebase cycles after a configuration change, measured at falling edges.
- R4: With `band_hi_i` = 1, the wait uses LOCK_HI_CYC instead. `ready_o` rises LOCK_HI_CYC + 3 cycles after the change, and a change of `band_hi_i` itself restarts the wait.
- R5: A configuration change during a running wait restarts the full wait. Ready then rises LOCK_LO_CYC + 3 cycles after the later change.
- R6: Two falling timebase edges after `pd_ni` goes low, `ready_o` is 0. `clk_o` stays low for as long as power-down lasts.
- R7: Configuration changes made during power-down have no effect: `ready_o` and `clk_o` stay 0. Releasing `pd_ni` starts a wait, and ready rises LOCK_LO_CYC + 3 cycles after the release.
- R8: Once ready, `clk_o` follows `pll_clk_i` and toggles. The gate changes only while `pll_clk_i` is low, so no partial pulse is produced.
- R9: The lock counter never reaches LOCK_HI_CYC.
- R10: The reset state means normal operation with a wait pending. With `pd_ni` = 1 and the configuration held at 0, `ready_o` rises exactly LOCK_LO_CYC cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low; 1 = normal operation |
| freq_sel_i | input | FREQ_W | Frequency-range select |
| mod_en_i | input | 1 | Modulation enable |
| band_hi_i | input | 1 | 1 selects the LOCK_HI_CYC wait, 0 selects LOCK_LO_CYC |
| pll_clk_i | input | 1 | Clock from the PLL |
| clk_o | output | 1 | Gated output clock, low unless ready |
| ready_o | output | 1 | Clock valid / downstream reset release |

## Verification
The assertions assume that every input is quasi-static relative to the timebase. Each level must be held for at least two timebase cycles so that the synchronizer delivers it, which lets a change show up as a single clean difference between the synchronized and registered copies. The bench drives all pins on falling timebase edges and holds each setting for many cycles. It never toggles a pin faster than the synchronizer can follow, and it runs the PLL clock unrelated to the timebase so that the gate crossing is exercised at changing phases.

// File: rtl/clk_sup_pkg.sv
package clk_sup_pkg;
  typedef enum logic [1:0] {
    SUP_OFF   = 2'd0,
    SUP_WAIT  = 2'd1,
    SUP_READY = 2'd2
  } sup_state_e;
endpackage

// File: rtl/clk_sup_sync.sv
module clk_sup_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clk_sup_timer.sv
module clk_sup_timer
  import clk_sup_pkg::*;
#(
  parameter int unsigned LOCK_LO_CYC = 250000,
  parameter int unsigned LOCK_HI_CYC = 400000,
  parameter int unsigned CNT_W       = $clog2(LOCK_HI_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,       // synchronized, 1 = running
  input  logic             restart_i,  // configuration change seen
  input  logic             band_hi_i,
  output sup_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] LO_LOAD = CNT_W'(LOCK_LO_CYC - 1);
  localparam logic [CNT_W-1:0] HI_LOAD = CNT_W'(LOCK_HI_CYC - 1);

  sup_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SUP_WAIT;
      cnt_q   <= LO_LOAD;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!pd_i) begin
      state_d = SUP_OFF;
      cnt_d   = '0;
    end else if (restart_i || state_q == SUP_OFF) begin
      state_d = SUP_WAIT;
      cnt_d   = band_hi_i ? HI_LOAD : LO_LOAD;
    end else if (state_q == SUP_WAIT) begin
      if (cnt_q == '0) state_d = SUP_READY;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  // drop in the detection cycle, before the state register reacts
  assign ready_o = (state_q == SUP_READY) && pd_i && !restart_i;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/clk_sup_gate.sv
module clk_sup_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic pll_clk_i,
  output logic gate_o,
  output logic clk_o
);
  logic gate_q, en_meta_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= ready_i;
  end

  always_ff @(posedge pll_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_meta_q <= 1'b0;
    else         en_meta_q <= gate_q;
  end

  // enable moves only while the PLL clock is low: whole pulses only
  always_ff @(negedge pll_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_meta_q;
  end

  assign gate_o = gate_q;
  assign clk_o  = pll_clk_i & en_q;
endmodule

// File: rtl/clk_lock_supervisor.sv
module clk_lock_supervisor
  import clk_sup_pkg::*;
#(
  parameter int unsigned FREQ_W      = 2,
  parameter int unsigned LOCK_LO_CYC = 250000,
  parameter int unsigned LOCK_HI_CYC = 400000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic [FREQ_W-1:0] freq_sel_i,
  input  logic              mod_en_i,
  input  logic              band_hi_i,
  input  logic              pll_clk_i,
  output logic              clk_o,
  output logic              ready_o
);
  localparam int unsigned CFG_W = FREQ_W + 2;
  localparam int unsigned CNT_W = $clog2(LOCK_HI_CYC + 1);

  logic             pd_s;
  logic [CFG_W-1:0] cfg_s, cfg_q;
  logic             cfg_change;
  sup_state_e       sup_state;
  logic [CNT_W-1:0] lock_cnt;
  logic             ready;
  logic             gate_open;

  // reset value 1: undriven power-down pin means normal operation
  clk_sup_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_ni),
    .q_o   (pd_s)
  );

  clk_sup_sync #(.W(CFG_W), .RST_VAL('0)) u_cfg_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({band_hi_i, mod_en_i, freq_sel_i}),
    .q_o   (cfg_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_s;
  end

  assign cfg_change = (cfg_s != cfg_q);

  clk_sup_timer #(
    .LOCK_LO_CYC(LOCK_LO_CYC),
    .LOCK_HI_CYC(LOCK_HI_CYC),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_i     (pd_s),
    .restart_i(cfg_change),
    .band_hi_i(cfg_s[CFG_W-1]),
    .state_o  (sup_state),
    .cnt_o    (lock_cnt),
    .ready_o  (ready)
  );

  clk_sup_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (ready),
    .pll_clk_i(pll_clk_i),
    .gate_o   (gate_open),
    .clk_o    (clk_o)
  );

  assign ready_o = ready;
endmodule

// File: rtl/clk_lock_supervisor_chk.sv
module clk_lock_supervisor_chk
  import clk_sup_pkg::*;
#(
  parameter int unsigned LOCK_HI_CYC = 400000,
  parameter int unsigned CNT_W       = $clog2(LOCK_HI_CYC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_s,
  input logic             change,
  input sup_state_e       state,
  input logic [CNT_W-1:0] cnt,
  input logic             ready_o,
  input logic             gate
);
  p_change_restarts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change && pd_s) |=> (state == SUP_WAIT && !ready_o));

  p_ready_after_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(state) == SUP_WAIT && $past(cnt) == '0));

  p_pd_blocks_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_s |-> !ready_o);

  p_pd_closes_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_s |=> !gate);

  p_off_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SUP_OFF && !pd_s) |=> state == SUP_OFF);

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SUP_WAIT) |-> (cnt < CNT_W'(LOCK_HI_CYC)));
endmodule

bind clk_lock_supervisor clk_lock_supervisor_chk #(
  .LOCK_HI_CYC(LOCK_HI_CYC),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pd_s   (pd_s),
  .change (cfg_change),
  .state  (sup_state),
  .cnt    (lock_cnt),
  .ready_o(ready_o),
  .gate   (gate_open)
);

// File: tb/clk_lock_supervisor_bench.sv
module clk_lock_supervisor_bench;
  localparam int unsigned FREQ_W = 2;
  localparam int unsigned N_LO   = 20;
  localparam int unsigned N_HI   = 32;

  logic              clk_i = 1'b0;
  logic              pll_clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pd_ni = 1'b1;
  logic [FREQ_W-1:0] freq_sel_i = '0;
  logic              mod_en_i = 1'b0;
  logic              band_hi_i = 1'b0;
  logic              clk_o, ready_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;     // 50 MHz timebase
  always #3  pll_clk_i = ~pll_clk_i;

  clk_lock_supervisor #(
    .FREQ_W(FREQ_W), .LOCK_LO_CYC(N_LO), .LOCK_HI_CYC(N_HI)
  ) u_clk_lock_supervisor (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .freq_sel_i(freq_sel_i),
    .mod_en_i(mod_en_i), .band_hi_i(band_hi_i), .pll_clk_i(pll_clk_i),
    .clk_o(clk_o), .ready_o(ready_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count falling edges until ready_o is seen high
  task automatic wait_ready(inout int n);
    while (!ready_o && n < 500) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic sample_clk(output int ones, output int zeros);
    ones = 0; zeros = 0;
    for (int i = 0; i < 60; i++) begin
      #1.7;
      if (clk_o) ones++; else zeros++;
    end
  endtask

  // apply a change from a ready state, check drop (R2) and the wait length
  task automatic change_measure(input string req, input int exp);
    int n = 0;
    @(negedge clk_i); n++;
    check(ready_o == 1'b1, "R2 ready held one edge", ready_o, 1);
    @(negedge clk_i); n++;
    check(ready_o == 1'b0, "R2 ready drop", ready_o, 0);
    wait_ready(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    int n = 0;
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b0, "R1 ready in reset", ready_o, 0);
    check(clk_o == 1'b0, "R1 clk_o in reset", clk_o, 0);
    rst_ni = 1'b1;
    wait_ready(n);
    check(n == N_LO, "R10 first wait after reset", n, N_LO);
  endtask

  task automatic t_clk_pass;
    int ones, zeros;
    repeat (6) @(negedge clk_i);
    sample_clk(ones, zeros);
    check(ones > 0 && zeros > 0, "R8 clk_o toggles when ready", ones, 1);
  endtask

  task automatic t_freq_change;
    freq_sel_i = 2'b01;
    change_measure("R3 freq change wait", N_LO + 3);
    freq_sel_i = 2'b11;
    change_measure("R3 second freq change wait", N_LO + 3);
  endtask

  task automatic t_mod_change;
    mod_en_i = 1'b1;
    change_measure("R3 modulation change wait", N_LO + 3);
  endtask

  task automatic t_band;
    band_hi_i = 1'b1;
    change_measure("R4 band switch wait", N_HI + 3);
    freq_sel_i = 2'b10;
    change_measure("R4 high band freq change wait", N_HI + 3);
    band_hi_i = 1'b0;
    change_measure("R4 back to low band wait", N_LO + 3);
  endtask

  task automatic t_restart;
    int n = 0;
    freq_sel_i = 2'b00;
    repeat (10) @(negedge clk_i);
    check(ready_o == 1'b0, "R5 ready low mid wait", ready_o, 0);
    mod_en_i = 1'b0;
    wait_ready(n);
    check(n == N_LO + 3, "R5 restart wait length", n, N_LO + 3);
  endtask

  task automatic t_powerdown;
    int n = 0;
    int ones, zeros;
    bit seen_ready = 1'b0;
    pd_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(ready_o == 1'b0, "R6 ready drop on power-down", ready_o, 0);
    repeat (8) @(negedge clk_i);
    sample_clk(ones, zeros);
    check(ones == 0, "R6 clk_o low in power-down", ones, 0);
    freq_sel_i = 2'b11;
    repeat (5) @(negedge clk_i);
    mod_en_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (ready_o) seen_ready = 1'b1;
    end
    check(!seen_ready, "R7 changes ignored in power-down", seen_ready, 0);
    sample_clk(ones, zeros);
    check(ones == 0, "R7 clk_o held low after changes", ones, 0);
    pd_ni = 1'b1;
    wait_ready(n);
    check(n == N_LO + 3, "R7 wait after release", n, N_LO + 3);
  endtask

  initial begin
    t_reset();
    t_clk_pass();
    t_freq_change();
    t_mod_change();
    t_band();
    t_restart();
    t_powerdown();
    t_clk_pass();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule